// File: doc/BRIEF.md
# GPIO Port Register Block

This block holds the control and data registers of one 16-pin general-purpose I/O port. Software reaches it through a simple 32-bit memory-mapped bus. The bus has a byte address inside a 1 KB window, a write strobe, write data, and combinational read data. Each pin has three settings: a 2-bit mode, a 1-bit output type and a 2-bit speed.

A 16-bit output latch sets what each pin drives. Software can change the latch in three ways:
- a write to the whole port at once;
- an atomic write that sets some bits and clears others in one access;
- a write that only clears bits.

The pin inputs pass through a two-flop synchronizer before software can read them.

A port clock-enable input gates every register write. While the enable is low, a write is dropped and changes nothing. The block drives a value and a drive-enable for each pin. A pin drives only in general-purpose output mode, either as push-pull or as open-drain.

Top module: `gpio_port_regs`

## Requirements
- R1: After reset, every register reads zero and every pin has drive-enable low and drive value low.
- R2: Offset 0x00 holds 2 mode bits per pin, pin n at bits 2n+1:2n. Offset 0x08 holds 2 speed bits per pin in the same layout. Offset 0x04 holds 1 output-type bit per pin in bits 15:0, and its bits 31:16 read as zero. All three read back what was written.
- R3: A write to offset 0x14 loads all 16 output latch bits from write data bits 15:0. Bits 31:16 are ignored, and offset 0x14 reads back the latch in bits 15:0.
- R4: A write to offset 0x18 sets latch bit n for each 1 in bit n (n = 0..15). It clears latch bit n for each 1 in bit n+16. Latch bits whose set and clear bits are both 0 keep their value. When both bits for a pin are 1, the set wins.
- R5: A write to offset 0x28 clears latch bit n for each 1 in write data bit n (n = 0..15). Bits 31:16 and the other latch bits are unaffected.
- R6: Offsets 0x18 and 0x28 read as zero. Every offset that is not mapped reads as zero and ignores writes. Only address bits 9:2 are decoded.
- R7: A write made while the clock-enable input is low changes no register and no latch bit.
- R8: In mode code 01 with output type 0 (push-pull), a pin has drive-enable 1 and drive value equal to its latch bit. In mode 01 with output type 1 (open-drain), the drive value is 0 and the drive-enable is the inverse of the latch bit. For mode codes 00, 10 and 11, drive-enable and drive value are both 0.
- R9: Offset 0x10 returns, in bits 15:0, the pin inputs as they were sampled two clock edges before. Its bits 31:16 read zero, and writes to it are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| clk_en_i | input | 1 | Port clock enable; writes are dropped while it is low |
| addr_i | input | 10 | Byte address inside the port window |
| we_i | input | 1 | Write strobe |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for addr_i (combinational) |
| pin_i | input | 16 | Pin input levels |
| pin_o | output | 16 | Per-pin drive value |
| pin_oe_o | output | 16 | Per-pin drive-enable |

## Verification
Two things can land on the same cycle:
- In one set/reset write, a pin can be set and cleared together. The bench provokes this with directed words that overlap both halves, and expects the set to win.
- A latch update and a drop by a gated clock-enable can fall on the same strobe. The bench writes every register with the enable low, then reads each one back, and expects the old value.

Random traffic mixes the enable, the offsets and the pin inputs. A behavioural model in the bench judges the read data and the pin outputs after every clock.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;
  localparam int unsigned NPINS = 16;
  localparam int unsigned DW    = 32;
  localparam int unsigned AW    = 10;
  localparam int unsigned WAW   = AW - 2;
  localparam int unsigned MW    = 2 * NPINS;

  // word indices inside the 1 KB window
  localparam logic [WAW-1:0] W_MODE  = WAW'(8'h00);
  localparam logic [WAW-1:0] W_OTYPE = WAW'(8'h01);
  localparam logic [WAW-1:0] W_SPEED = WAW'(8'h02);
  localparam logic [WAW-1:0] W_IDR   = WAW'(8'h04);
  localparam logic [WAW-1:0] W_ODR   = WAW'(8'h05);
  localparam logic [WAW-1:0] W_BSRR  = WAW'(8'h06);
  localparam logic [WAW-1:0] W_BRR   = WAW'(8'h0A);

  typedef enum logic [1:0] {
    MODE_IN  = 2'b00,
    MODE_OUT = 2'b01,
    MODE_ALT = 2'b10,
    MODE_ANA = 2'b11
  } pin_mode_e;
endpackage

// File: rtl/gpio_cfg_regs.sv
module gpio_cfg_regs
  import gpio_port_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clk_en_i,
  input  logic             we_i,
  input  logic             sel_mode_i,
  input  logic             sel_otype_i,
  input  logic             sel_speed_i,
  input  logic [DW-1:0]    wdata_i,
  output logic [MW-1:0]    mode_o,
  output logic [NPINS-1:0] otype_o,
  output logic [MW-1:0]    speed_o
);
  logic wr;
  assign wr = clk_en_i & we_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_o  <= '0;
      otype_o <= '0;
      speed_o <= '0;
    end else if (wr) begin
      if (sel_mode_i)  mode_o  <= wdata_i[MW-1:0];
      if (sel_otype_i) otype_o <= wdata_i[NPINS-1:0];
      if (sel_speed_i) speed_o <= wdata_i[MW-1:0];
    end
  end

  a_r7_cfg_gated: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clk_en_i |=> ($stable(mode_o) && $stable(otype_o) && $stable(speed_o)));
  a_r2_mode_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clk_en_i && we_i && sel_mode_i) |=> mode_o == $past(wdata_i[MW-1:0]));
endmodule

// File: rtl/gpio_out_latch.sv
module gpio_out_latch
  import gpio_port_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clk_en_i,
  input  logic             we_i,
  input  logic             sel_odr_i,
  input  logic             sel_bsrr_i,
  input  logic             sel_brr_i,
  input  logic [DW-1:0]    wdata_i,
  output logic [NPINS-1:0] odr_o
);
  logic [NPINS-1:0] set_bits, clr_bits, odr_d;
  logic             wr;

  assign wr       = clk_en_i & we_i;
  assign set_bits = wdata_i[NPINS-1:0];
  assign clr_bits = wdata_i[2*NPINS-1:NPINS];

  always_comb begin
    odr_d = odr_o;
    if (wr) begin
      if (sel_odr_i)       odr_d = set_bits;
      else if (sel_bsrr_i) odr_d = (odr_o & ~clr_bits) | set_bits; // set wins
      else if (sel_brr_i)  odr_d = odr_o & ~set_bits;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) odr_o <= '0;
    else         odr_o <= odr_d;
  end

  a_r7_odr_gated: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clk_en_i |=> $stable(odr_o));
  a_r3_odr_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr && sel_odr_i) |=> odr_o == $past(wdata_i[NPINS-1:0]));
  a_r4_set_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr && sel_bsrr_i) |=> (odr_o & $past(set_bits)) == $past(set_bits));
  a_r4_clear_only: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr && sel_bsrr_i) |=> (odr_o & $past(clr_bits & ~set_bits)) == '0);
  a_r5_brr_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr && sel_brr_i) |=> (odr_o & $past(set_bits)) == '0);
endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync
  import gpio_port_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [NPINS-1:0] pin_i,
  output logic [NPINS-1:0] sync_o
);
  logic [NPINS-1:0] meta_q;
  logic [1:0]       warm_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= '0;
      sync_o <= '0;
      warm_q <= '0;
    end else begin
      meta_q <= pin_i;
      sync_o <= meta_q;
      if (warm_q != 2'd2) warm_q <= warm_q + 2'd1;
    end
  end

  a_r9_two_stage: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (warm_q == 2'd2) |-> sync_o == $past(pin_i, 2));
endmodule

// File: rtl/gpio_pad_ctrl.sv
module gpio_pad_ctrl
  import gpio_port_pkg::*;
(
  input  logic [MW-1:0]    mode_i,
  input  logic [NPINS-1:0] otype_i,
  input  logic [NPINS-1:0] odr_i,
  output logic [NPINS-1:0] pin_o,
  output logic [NPINS-1:0] pin_oe_o
);
  for (genvar i = 0; i < NPINS; i++) begin : g_pin
    pin_mode_e m;
    assign m = pin_mode_e'(mode_i[2*i +: 2]);
    always_comb begin
      pin_o[i]    = 1'b0;
      pin_oe_o[i] = 1'b0;
      if (m == MODE_OUT) begin
        if (otype_i[i]) pin_oe_o[i] = ~odr_i[i];  // open-drain: release on 1
        else begin
          pin_oe_o[i] = 1'b1;
          pin_o[i]    = odr_i[i];
        end
      end
    end
  end

  always_comb begin
    a_r8_od_never_high: assert ((pin_o & pin_oe_o & otype_i) == '0);
  end
endmodule

// File: rtl/gpio_port_regs.sv
module gpio_port_regs
  import gpio_port_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clk_en_i,
  input  logic [AW-1:0]    addr_i,
  input  logic             we_i,
  input  logic [DW-1:0]    wdata_i,
  output logic [DW-1:0]    rdata_o,
  input  logic [NPINS-1:0] pin_i,
  output logic [NPINS-1:0] pin_o,
  output logic [NPINS-1:0] pin_oe_o
);
  logic [WAW-1:0]   widx;
  logic [MW-1:0]    mode, speed;
  logic [NPINS-1:0] otype, odr, idr;
  logic             unused_bits;

  assign widx        = addr_i[AW-1:2];
  assign unused_bits = ^addr_i[1:0];

  gpio_cfg_regs u_cfg (
    .clk_i, .rst_ni, .clk_en_i, .we_i,
    .sel_mode_i  (widx == W_MODE),
    .sel_otype_i (widx == W_OTYPE),
    .sel_speed_i (widx == W_SPEED),
    .wdata_i,
    .mode_o  (mode),
    .otype_o (otype),
    .speed_o (speed)
  );

  gpio_out_latch u_out (
    .clk_i, .rst_ni, .clk_en_i, .we_i,
    .sel_odr_i  (widx == W_ODR),
    .sel_bsrr_i (widx == W_BSRR),
    .sel_brr_i  (widx == W_BRR),
    .wdata_i,
    .odr_o (odr)
  );

  gpio_in_sync u_sync (.clk_i, .rst_ni, .pin_i, .sync_o(idr));

  gpio_pad_ctrl u_pad (
    .mode_i (mode), .otype_i (otype), .odr_i (odr), .pin_o, .pin_oe_o
  );

  always_comb begin
    rdata_o = '0;
    unique case (widx)
      W_MODE:  rdata_o[MW-1:0]    = mode;
      W_OTYPE: rdata_o[NPINS-1:0] = otype;
      W_SPEED: rdata_o[MW-1:0]    = speed;
      W_IDR:   rdata_o[NPINS-1:0] = idr;
      W_ODR:   rdata_o[NPINS-1:0] = odr;
      default: rdata_o = '0;   // set/reset, reset-only and holes read zero
    endcase
  end

  a_r6_strobe_regs_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (widx == W_BSRR || widx == W_BRR) |-> rdata_o == '0);
  a_r8_idle_pins_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode == '0) |-> (pin_oe_o == '0 && pin_o == '0));
endmodule

// File: tb/gpio_port_regs_tb.sv
module gpio_port_regs_tb;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        clk_en = 1'b1;
  logic [9:0]  addr = '0;
  logic        we = 1'b0;
  logic [31:0] wdata = '0;
  logic [15:0] pin_in = '0;
  logic [31:0] rdata;
  logic [15:0] pin_o, pin_oe;
  int vecs = 0, errs = 0;

  always #10 clk = ~clk;  // 50 MHz

  gpio_port_regs u_dut (
    .clk_i(clk), .rst_ni, .clk_en_i(clk_en), .addr_i(addr), .we_i(we),
    .wdata_i(wdata), .rdata_o(rdata), .pin_i(pin_in), .pin_o, .pin_oe_o(pin_oe)
  );

  // behavioural reference
  logic [31:0] m_mode, m_speed;
  logic [15:0] m_otype, m_odr;
  logic [15:0] sq[$];   // two-deep input pipeline

  always @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      m_mode = 0; m_speed = 0; m_otype = 0; m_odr = 0;
      sq = '{16'h0, 16'h0};
    end else begin
      sq.push_back(pin_in);
      void'(sq.pop_front());
      if (we && clk_en) begin
        case (addr[9:2])
          8'h00: m_mode  = wdata;
          8'h01: m_otype = wdata[15:0];
          8'h02: m_speed = wdata;
          8'h05: m_odr   = wdata[15:0];
          8'h06: m_odr   = (m_odr & ~wdata[31:16]) | wdata[15:0];
          8'h0A: m_odr   = m_odr & ~wdata[15:0];
          default: ;
        endcase
      end
    end
  end

  function automatic logic [31:0] exp_rd(input logic [9:0] a);
    case (a[9:2])
      8'h00: return m_mode;
      8'h01: return {16'h0, m_otype};
      8'h02: return m_speed;
      8'h04: return {16'h0, sq[0]};
      8'h05: return {16'h0, m_odr};
      default: return 32'h0;
    endcase
  endfunction

  task automatic compare(input string req);
    logic [15:0] eo = '0, eoe = '0;
    for (int i = 0; i < 16; i++) begin
      if (m_mode[2*i +: 2] == 2'b01) begin
        if (m_otype[i]) eoe[i] = ~m_odr[i];
        else begin eoe[i] = 1'b1; eo[i] = m_odr[i]; end
      end
    end
    vecs++;
    if (rdata !== exp_rd(addr)) begin
      errs++;
      $display("FAIL %s addr=%h rdata=%h expected=%h", req, addr, rdata, exp_rd(addr));
    end
    if (pin_oe !== eoe || pin_o !== eo) begin
      errs++;
      $display("FAIL R8 (%s) oe=%h out=%h expected oe=%h out=%h", req, pin_oe, pin_o, eoe, eo);
    end
  endtask

  task automatic cyc(input logic [9:0] a, input logic w, input logic [31:0] d,
                     input logic en, input string req);
    addr = a; we = w; wdata = d; clk_en = en;
    @(posedge clk);
    @(negedge clk);
    compare(req);
  endtask

  task automatic rd(input logic [9:0] a, input string req);
    cyc(a, 1'b0, 32'h0, 1'b1, req);
  endtask

  task automatic wr(input logic [9:0] a, input logic [31:0] d, input string req);
    cyc(a, 1'b1, d, 1'b1, req);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errs++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    // R1 reset state
    foreach (sq[i]) ;
    rd(10'h000, "R1"); rd(10'h004, "R1"); rd(10'h008, "R1");
    rd(10'h010, "R1"); rd(10'h014, "R1");
    // R2 configuration readback
    wr(10'h000, 32'h9C63_5A0F, "R2"); rd(10'h000, "R2");
    wr(10'h004, 32'hFFFF_00F0, "R2"); rd(10'h004, "R2");
    wr(10'h008, 32'hDEAD_BEEF, "R2"); rd(10'h008, "R2");
    // R3 whole-port write, upper bits ignored
    wr(10'h014, 32'hFFFF_A5C3, "R3"); rd(10'h014, "R3");
    wr(10'h014, 32'h1234_0000, "R3"); rd(10'h014, "R3");
    // R4 set/reset
    wr(10'h018, 32'h0000_00FF, "R4"); rd(10'h014, "R4");
    wr(10'h018, 32'h000F_0000, "R4"); rd(10'h014, "R4");
    wr(10'h018, 32'h0F0F_0F00, "R4 set wins"); rd(10'h014, "R4 set wins");
    wr(10'h018, 32'h0000_0000, "R4 no-op"); rd(10'h014, "R4");
    // R5 reset-only
    wr(10'h014, 32'h0000_FFFF, "R5");
    wr(10'h028, 32'hFFFF_1001, "R5"); rd(10'h014, "R5");
    // R6 reads of strobe registers and holes, byte offsets, hole writes
    rd(10'h018, "R6"); rd(10'h028, "R6"); rd(10'h3FC, "R6"); rd(10'h00C, "R6");
    wr(10'h02C, 32'hFFFF_FFFF, "R6"); rd(10'h014, "R6");
    wr(10'h016, 32'h0000_3C3C, "R6 byte bits"); rd(10'h015, "R6 byte bits");
    // R7 gated writes
    cyc(10'h000, 1'b1, 32'h0, 1'b0, "R7"); cyc(10'h004, 1'b1, 32'h0, 1'b0, "R7");
    cyc(10'h008, 1'b1, 32'h0, 1'b0, "R7"); cyc(10'h014, 1'b1, 32'h0, 1'b0, "R7");
    cyc(10'h018, 1'b1, 32'hFFFF_0000, 1'b0, "R7");
    cyc(10'h028, 1'b1, 32'h0000_FFFF, 1'b0, "R7");
    rd(10'h000, "R7"); rd(10'h004, "R7"); rd(10'h008, "R7"); rd(10'h014, "R7");
    // R8 drive modes: every mode code, both output types, both latch values
    wr(10'h000, 32'h5555_5555, "R8");
    wr(10'h004, 32'h0000_0000, "R8"); wr(10'h014, 32'h0000_AAAA, "R8");
    wr(10'h004, 32'h0000_FF00, "R8"); wr(10'h014, 32'h0000_0F0F, "R8");
    wr(10'h000, 32'hE4E4_E4E4, "R8"); wr(10'h014, 32'h0000_FFFF, "R8");
    wr(10'h004, 32'h0000_3333, "R8"); wr(10'h014, 32'h0000_0000, "R8");
    // R9 input synchronizer latency, writes to the input register ignored
    pin_in = 16'hBEEF; rd(10'h010, "R9"); rd(10'h010, "R9");
    pin_in = 16'h1357; rd(10'h010, "R9");
    pin_in = 16'h0000; rd(10'h010, "R9"); rd(10'h010, "R9"); rd(10'h010, "R9");
    wr(10'h010, 32'hFFFF_FFFF, "R9"); rd(10'h010, "R9");
    // mixed random traffic
    for (int k = 0; k < 600; k++) begin
      logic [9:0] a;
      case ($urandom_range(0, 7))
        0: a = 10'h000; 1: a = 10'h004; 2: a = 10'h008; 3: a = 10'h010;
        4: a = 10'h014; 5: a = 10'h018; 6: a = 10'h028;
        default: a = 10'($urandom_range(0, 1023));
      endcase
      pin_in = 16'($urandom);
      cyc(a, 1'($urandom), $urandom, ($urandom_range(0, 3) != 0), "R3 R4 R5 R7 random");
    end
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end
endmodule